// File: doc/BRIEF.md
# Repeating Memory-to-Stream Reader

This block copies one fixed-size buffer out of byte-addressed memory and presents it as a stream of memory-width words. It runs the copy a run-time number of times per start. The buffer size is set when the block is built and is a whole number of memory words. At start, the block captures a base byte address, a repetition count and an addressing mode.

In replay mode, every repetition reads the same buffer again from the base address. This suits constant data such as weights that a consumer needs on every pass. In advance mode, each repetition picks up at the byte just after the end of the previous one, so a run of back-to-back images is read in one go. The base address may be any byte address; addresses step by the word size in bytes.

Memory reads use two valid/ready channels: a request channel that carries an address, and a response channel whose words come back in request order. The output is a valid/ready stream. It flags the final word of each repetition, and the stream's back-pressure holds it still. The block only issues a read while the number of reads issued but not yet taken by the output stays below a build-time limit, so response words always have room and are never refused for lack of space. An offered request or output word keeps its valid, address, data and last flag steady until it is accepted.

Top module: `mem_stream_reader`

## Requirements
- R1: After reset, busy, done, the request valid and the output valid are all low.
- R2: The output words are the memory words read at byte addresses base + k*(WORD_W/8), emitted in request order with no word lost or repeated.
- R3: With wrap_mode = 1 (replay), every repetition reads from the base address again.
- R4: With wrap_mode = 0 (advance), repetition r (counted from 0) starts at base + r*XFER_BYTES.
- R5: The output last flag is high on the final word of each repetition and low on every other word.
- R6: done is high for exactly the one cycle after the last word of the last repetition is accepted, and busy is low from that same cycle on.
- R7: A start with a repetition count of zero gives a done pulse in the following cycle, issues no memory read and leaves busy low.
- R8: Reads issued minus output words accepted never exceeds MAX_INFLIGHT.
- R9: A request or an output word that is offered but not accepted keeps its valid high and its contents unchanged in the next cycle.
- R10: A start pulse while busy is high is ignored; the transfer in progress continues unchanged.
- R11: A base address that is not a multiple of the word size is accepted, and the addresses step from it by the word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer; taken only while idle |
| base_addr | input | ADDR_W | Byte address of the first word |
| rep_count | input | REPS_W | Number of repetitions |
| wrap_mode | input | 1 | 1 = replay from base, 0 = advance |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Memory takes the request |
| rd_req_addr | output | ADDR_W | Byte address of the request |
| rd_rsp_valid | input | 1 | Read response offered |
| rd_rsp_ready | output | 1 | Block takes the response |
| rd_rsp_data | input | WORD_W | Response word |
| m_valid | output | 1 | Output word offered |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | WORD_W | Output word |
| m_last | output | 1 | Final word of a repetition |

## Verification
The hardest case to reach from the ports is the read limit under pressure. The consumer must stall long enough that issued-but-unconsumed reads reach MAX_INFLIGHT. At the same time, memory must keep accepting requests and returning responses. The bench gets there with a run in which the output ready is mostly low while the request ready and the response valid are mostly high. It tracks the issued-minus-accepted count at every cycle. A start pulse with a different base address is also injected mid-run, to show that a busy transfer ignores it.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic {
    MODE_ADVANCE = 1'b0,
    MODE_REPLAY  = 1'b1
  } addr_mode_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msr_req_gen.sv
module msr_req_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4,
  parameter int WORDS  = 8,
  parameter int REPS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base,
  input  logic [REPS_W-1:0] reps,
  input  msr_pkg::addr_mode_e mode,
  input  logic              credit_ok,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int IDX_W = msr_pkg::idx_width(WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  logic                active;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   base_q;
  msr_pkg::addr_mode_e mode_q;
  logic [IDX_W-1:0]    widx;
  logic [REPS_W-1:0]   reps_left;
  logic                fire;

  assign req_valid = active && credit_ok;
  assign req_addr  = addr_q;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      addr_q    <= '0;
      base_q    <= '0;
      mode_q    <= msr_pkg::MODE_ADVANCE;
      widx      <= '0;
      reps_left <= '0;
    end else if (launch) begin
      active    <= 1'b1;
      addr_q    <= base;
      base_q    <= base;
      mode_q    <= mode;
      widx      <= '0;
      reps_left <= reps;
    end else if (fire) begin
      if (widx == IDX_LAST) begin
        widx      <= '0;
        reps_left <= reps_left - 1'b1;
        if (reps_left == REPS_W'(1)) active <= 1'b0;
        if (mode_q == msr_pkg::MODE_REPLAY) addr_q <= base_q;
        else                                addr_q <= addr_q + ADDR_W'(STEP);
      end else begin
        widx   <= widx + 1'b1;
        addr_q <= addr_q + ADDR_W'(STEP);
      end
    end
  end
endmodule

// File: rtl/msr_credit.sv
module msr_credit #(
  parameter int MAX_INFLIGHT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issued,
  input  logic consumed,
  output logic credit_ok
);
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_INFLIGHT);

  logic [CNT_W-1:0] inflight;

  assign credit_ok = inflight < LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else begin
      case ({issued, consumed})
        2'b10:   inflight <= inflight + 1'b1;
        2'b01:   inflight <= inflight - 1'b1;
        default: inflight <= inflight;
      endcase
    end
  end
endmodule

// File: rtl/msr_fifo.sv
module msr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PTR_W = msr_pkg::idx_width(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = count == CNT_W'(DEPTH);
  assign empty   = count == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rd_ptr];

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) if (do_push) store[0] <= din;
    end else begin : g_ring
      always_ff @(posedge clk) if (do_push) store[wr_ptr] <= din;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/msr_out_track.sv
module msr_out_track #(
  parameter int WORDS  = 8,
  parameter int REPS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_empty,
  input  logic [REPS_W-1:0] reps,
  input  logic              beat,
  output logic              at_last,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = msr_pkg::idx_width(WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0]  oidx;
  logic [REPS_W-1:0] reps_left;

  assign at_last = oidx == IDX_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oidx      <= '0;
      reps_left <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch_empty) begin
        done <= 1'b1;
      end else if (launch) begin
        busy      <= 1'b1;
        oidx      <= '0;
        reps_left <= reps;
      end else if (beat && busy) begin
        if (at_last) begin
          oidx      <= '0;
          reps_left <= reps_left - 1'b1;
          if (reps_left == REPS_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          oidx <= oidx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mem_stream_reader.sv
module mem_stream_reader #(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int XFER_BYTES   = 32,
  parameter int REPS_W       = 8,
  parameter int MAX_INFLIGHT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [REPS_W-1:0] rep_count,
  input  logic              wrap_mode,
  output logic              busy,
  output logic              done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_last
);
  localparam int STEP  = WORD_W / 8;
  localparam int WORDS = XFER_BYTES / STEP;

  logic accept, launch, launch_empty;
  logic req_fire, rsp_fire, beat;
  logic credit_ok, fifo_full, fifo_empty, at_last;
  msr_pkg::addr_mode_e mode;

  assign mode         = wrap_mode ? msr_pkg::MODE_REPLAY : msr_pkg::MODE_ADVANCE;
  assign accept       = start && !busy;
  assign launch       = accept && (rep_count != '0);
  assign launch_empty = accept && (rep_count == '0);
  assign req_fire     = rd_req_valid && rd_req_ready;
  assign rsp_fire     = rd_rsp_valid && rd_rsp_ready;
  assign beat         = m_valid && m_ready;
  assign rd_rsp_ready = !fifo_full;
  assign m_valid      = !fifo_empty;
  assign m_last       = m_valid && at_last;

  msr_req_gen #(
    .ADDR_W(ADDR_W), .STEP(STEP), .WORDS(WORDS), .REPS_W(REPS_W)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .launch(launch), .base(base_addr),
    .reps(rep_count), .mode(mode), .credit_ok(credit_ok),
    .req_ready(rd_req_ready), .req_valid(rd_req_valid), .req_addr(rd_req_addr)
  );

  msr_credit #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_credit (
    .clk(clk), .rst_n(rst_n), .issued(req_fire), .consumed(beat),
    .credit_ok(credit_ok)
  );

  msr_fifo #(.W(WORD_W), .DEPTH(MAX_INFLIGHT)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rsp_fire), .din(rd_rsp_data),
    .full(fifo_full), .pop(beat), .dout(m_data), .empty(fifo_empty)
  );

  msr_out_track #(.WORDS(WORDS), .REPS_W(REPS_W)) u_track (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_empty(launch_empty),
    .reps(rep_count), .beat(beat), .at_last(at_last), .busy(busy), .done(done)
  );
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int MAX_INFLIGHT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data,
  input logic              m_last
);
  localparam int CW = $clog2(MAX_INFLIGHT + 2) + 1;
  logic [CW-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else pending <= pending + CW'(rd_req_valid && rd_req_ready)
                            - CW'(m_valid && m_ready);
  end

  p_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CW'(MAX_INFLIGHT));
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_idle_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid);
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);
endmodule

bind mem_stream_reader msr_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last)
);

// File: tb/mem_stream_reader_tb.sv
module mem_stream_reader_tb;
  localparam int AW = 32, DW = 32, XB = 24, RW = 8, MI = 3;
  localparam int STEP = DW / 8, WORDS = XB / STEP;

  logic clk = 0, rst_n = 0;
  logic start = 0, wrap_mode = 0;
  logic [AW-1:0] base_addr = '0;
  logic [RW-1:0] rep_count = '0;
  logic busy, done, rd_req_valid, rd_rsp_ready, m_valid, m_last;
  logic rd_req_ready = 0, rd_rsp_valid = 0, m_ready = 0;
  logic [AW-1:0] rd_req_addr;
  logic [DW-1:0] rd_rsp_data = '0, m_data;

  always #2 clk = ~clk;

  mem_stream_reader #(.ADDR_W(AW), .WORD_W(DW), .XFER_BYTES(XB),
    .REPS_W(RW), .MAX_INFLIGHT(MI)) u_dut (.*);

  int checks = 0, fails = 0;
  logic [AW-1:0] pend_addr[$];
  logic [DW:0]   exp_q[$];
  int  inflight = 0, req_seen = 0, done_seen = 0;
  int  req_pct = 80, rsp_pct = 80, out_pct = 80;
  bit  pend_done = 0, allow_done = 0;
  string tag = "R2";

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a ^ {a[15:0], 16'hC3A5};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pend_done) begin
        chk(done && !busy, "R6", "done/busy after final beat", {done, busy}, 2'b10);
        pend_done = 0;
        done_seen++;
      end else if (done && !allow_done)
        chk(0, "R6", "unexpected done", 1, 0);
      if (rd_req_valid && rd_req_ready) begin
        pend_addr.push_back(rd_req_addr);
        req_seen++; inflight++;
      end
      if (rd_rsp_valid && rd_rsp_ready) void'(pend_addr.pop_front());
      if (m_valid && m_ready) begin
        inflight--;
        if (exp_q.size() == 0) chk(0, "R2", "unexpected word", m_data, 0);
        else begin
          logic [DW:0] e;
          e = exp_q.pop_front();
          chk(m_data == e[DW-1:0], tag, "data", m_data, e[DW-1:0]);
          chk(m_last == e[DW], "R5", "last flag", m_last, e[DW]);
          chk(inflight <= MI, "R8", "reads outstanding", inflight, MI);
          if (exp_q.size() == 0) pend_done = 1;
        end
      end
      @(posedge clk); #1;
      rd_req_ready = $urandom_range(0, 99) < req_pct;
      rd_rsp_valid = pend_addr.size() > 0 && $urandom_range(0, 99) < rsp_pct;
      rd_rsp_data  = pend_addr.size() > 0 ? mem_word(pend_addr[0]) : '0;
      m_ready      = $urandom_range(0, 99) < out_pct;
    end
  end

  task automatic run(input logic [AW-1:0] base, input int reps, input bit wrap,
                     input string t, input bit poke);
    int d0;
    d0 = done_seen;
    tag = t;
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < WORDS; k++) begin
        logic [AW-1:0] a;
        a = wrap ? base + AW'(k * STEP) : base + AW'((r * WORDS + k) * STEP);
        exp_q.push_back({k == WORDS - 1, mem_word(a)});
      end
    @(posedge clk); #1;
    base_addr = base; rep_count = RW'(reps); wrap_mode = wrap; start = 1;
    @(posedge clk); #1; start = 0;
    if (poke) begin
      repeat (3) @(posedge clk); #1;
      base_addr = 32'hDEAD_0000; rep_count = 1; wrap_mode = ~wrap; start = 1; // R10
      @(posedge clk); #1; start = 0;
    end
    while (done_seen == d0) @(negedge clk);
    chk(exp_q.size() == 0 && !busy && !m_valid, "R6", "idle after run",
        exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk({busy, done, rd_req_valid, m_valid} == 4'b0, "R1", "reset outputs",
        {busy, done, rd_req_valid, m_valid}, 0);

    run(32'h0000_1000, 3, 0, "R4", 0);
    run(32'h0000_2000, 3, 1, "R3", 0);
    run(32'h0000_3003, 2, 0, "R11", 0);
    run(32'h0000_4001, 2, 1, "R11", 0);
    req_pct = 95; rsp_pct = 95; out_pct = 10;
    run(32'h0000_5000, 4, 0, "R8", 0);
    req_pct = 60; rsp_pct = 60; out_pct = 70;
    run(32'h0000_6000, 2, 0, "R10", 1);
    req_pct = 100; rsp_pct = 100; out_pct = 100;
    run(32'h0000_7000, 1, 0, "R2", 0);

    begin // R7: zero repetitions
      int r0;
      r0 = req_seen; allow_done = 1;
      @(posedge clk); #1; base_addr = 32'h8000; rep_count = 0; start = 1;
      @(posedge clk); #1; start = 0;
      @(negedge clk);
      chk(done && !busy, "R7", "zero count done", {done, busy}, 2'b10);
      @(negedge clk);
      chk(!done, "R7", "done one cycle", done, 0);
      repeat (4) @(negedge clk);
      chk(req_seen == r0 && !busy, "R7", "no reads", req_seen - r0, 0);
      allow_done = 0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule